// File: doc/BRIEF.md
# Shared-Timebase Compare/Capture Array

A single 16-bit up-counter is shared by five independent channels. Each channel owns a mode byte and a 16-bit compare/capture register. Depending on its mode byte, a channel can do one of four jobs. It can latch the counter when its input pin has an edge. It can raise a flag when the counter reaches a programmed value, which makes it a software timer. It can also flip its output pin on such a match, or produce an 8-bit pulse-width-modulated output. The counter steps on one of four selectable sources, and a rollover sets an overflow flag.

Software reaches the block through a byte-wide register port. Writes take effect on the next rising clock edge, and reads are combinational from the addressed register. Writing the low half of a channel's compare register disarms its comparator, and writing the high half arms it. A duty-cycle or timer value can therefore be written low byte first without a spurious match in between. A single interrupt line combines the overflow request with the five channel requests, and each request has its own enable.

Register map (5-bit address): 0x00 control, 0x01 flags, 0x02/0x03 counter low/high, 0x08+n mode of channel n, 0x10+n compare low of channel n, 0x18+n compare high of channel n.

Top module: `ctr_compare_array`

## Requirements
- R1: After reset every register reads zero, all `cex_out` bits are 0 and `irq` is 0; unmapped addresses read zero.
- R2: Control bit 0 enables counting, and control bits [2:1] pick the step source: 0 gives one step every 6 clocks, 1 gives one step every 2 clocks, 2 gives one step per clock with `t0_ovf` high, and 3 gives one step per rising edge of `eci`. With bit 0 clear the counter holds.
- R3: With control bit 3 set and `idle` high, the counter holds. With `idle` low it counts normally.
- R4: A step from 0xFFFF wraps the counter to 0 and sets flags bit 7. `irq` follows that flag only when control bit 4 is set.
- R5: A write to the flags register loads bit n into channel n's flag and bit 7 into the overflow flag, so software clears a flag by writing 0. A hardware set on the same edge wins.
- R6: Mode byte bits: 6 arm (compare enable), 5 capture on rising edge, 4 capture on falling edge, 3 match flag, 2 toggle, 1 PWM, 0 interrupt enable. Bit 7 always reads 0.
- R7: With arm and match flag set, a step taken while the counter equals the compare register sets that channel's flag (flags bit n) on that same edge. A step at any other value leaves the flag clear.
- R8: With arm, match flag and toggle set, each such match also inverts `cex_out[n]`.
- R9: A capture copies the full counter into the compare register and sets the flag on the first clock edge at which the sampled pin differs from its previous sample in an enabled direction. With both edge bits set, either direction captures.
- R10: Writing compare-low clears mode bit 6, and writing compare-high sets it.
- R11: With arm and PWM set, `cex_out[n]` is 0 while the counter's low byte is below the compare-low byte, and 1 otherwise.
- R12: In PWM mode, a step from a counter low byte of 0xFF copies compare-high into compare-low.
- R13: `irq` is high when any channel has both its flag and mode bit 0 set, or when the overflow request of R4 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| idle | input | 1 | Device idle indication |
| t0_ovf | input | 1 | Timer overflow step request |
| eci | input | 1 | External count input |
| cex_in | input | 5 | Channel pins, input side |
| cex_out | output | 5 | Channel pins, output side |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong counter state shows at once on the counter readback. Through compare logic, it shows as a flag set one step early or late, or as a PWM level that disagrees with the low-byte comparison in the same cycle. A stale compare register or a lost arm bit shows as a missing flag on the step that should match, or as a capture readback that differs from the frozen counter on the edge after the pin change. Stepping from `t0_ovf` lets the bench place every step on a known edge, so each of these faults is seen within one step.

// File: rtl/cca_pkg.sv
package cca_pkg;

    typedef struct packed {
        logic rsv;
        logic ecom;
        logic capp;
        logic capn;
        logic mat;
        logic tog;
        logic pwm;
        logic eccf;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_T0   = 2'd2,
        SRC_EXT  = 2'd3
    } src_t;

    localparam int A_CTRL  = 0;
    localparam int A_FLAGS = 1;
    localparam int A_CNTL  = 2;
    localparam int A_CNTH  = 3;
    localparam int A_MODE  = 8;
    localparam int A_CMPL  = 16;
    localparam int A_CMPH  = 24;

    localparam int C_RUN   = 0;
    localparam int C_IDLE  = 3;
    localparam int C_OVFIE = 4;

endpackage

// File: rtl/cca_tick.sv
module cca_tick
    import cca_pkg::*;
#(
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_t sel,
    input  logic t0_ovf,
    input  logic eci,
    output logic tick
);
    localparam int SW = $clog2(SLOW_DIV);
    localparam int FW = $clog2(FAST_DIV);

    typedef struct packed {
        logic [SW-1:0] slow;
        logic [FW-1:0] fast;
        logic          eci;
    } tk_t;

    tk_t q, d;

    always_comb begin
        d      = q;
        d.slow = (q.slow == SW'(SLOW_DIV - 1)) ? '0 : q.slow + 1'b1;
        d.fast = (q.fast == FW'(FAST_DIV - 1)) ? '0 : q.fast + 1'b1;
        d.eci  = eci;
        case (sel)
            SRC_SLOW: tick = (q.slow == SW'(SLOW_DIV - 1));
            SRC_FAST: tick = (q.fast == FW'(FAST_DIV - 1));
            SRC_T0:   tick = t0_ovf;
            default:  tick = eci & ~q.eci;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    fast_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_FAST && $past(sel == SRC_FAST && tick)) |-> !tick);

endmodule

// File: rtl/cca_channel.sv
module cca_channel
    import cca_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [2*DATA_W-1:0] cnt,
    input  logic                mode_we,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic                flag_we,
    input  logic                flag_wbit,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                pin_in,
    output logic [7:0]          mode_o,
    output logic [2*DATA_W-1:0] cmp_o,
    output logic                flag_o,
    output logic                pin_out,
    output logic                req
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             tog;
        logic             pin;
    } ch_t;

    ch_t  q, d;
    logic rise, fall, capture, match, wrap;

    always_comb begin
        rise    = pin_in & ~q.pin;
        fall    = ~pin_in & q.pin;
        capture = (q.mode.capp & rise) | (q.mode.capn & fall);
        match   = step & q.mode.ecom & q.mode.mat & (cnt == q.cmp);
        wrap    = step & q.mode.pwm & (cnt[DATA_W-1:0] == '1);

        d     = q;
        d.pin = pin_in;
        if (capture)   d.cmp = cnt;
        else if (wrap) d.cmp[DATA_W-1:0] = q.cmp[CNT_W-1:DATA_W];
        if (lo_we) begin
            d.cmp[DATA_W-1:0] = wdata;
            d.mode.ecom       = 1'b0;
        end
        if (hi_we) begin
            d.cmp[CNT_W-1:DATA_W] = wdata;
            d.mode.ecom           = 1'b1;
        end
        if (mode_we) begin
            d.mode     = mode_t'(wdata[7:0]);
            d.mode.rsv = 1'b0;
        end
        if (match & q.mode.tog) d.tog = ~q.tog;
        d.flag = flag_we ? flag_wbit : q.flag;
        if (match | capture) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o  = q.mode;
    assign cmp_o   = q.cmp;
    assign flag_o  = q.flag;
    assign req     = q.flag & q.mode.eccf;
    assign pin_out = (q.mode.ecom & q.mode.pwm)
                   ? (cnt[DATA_W-1:0] >= q.cmp[DATA_W-1:0]) : q.tog;

    // R10
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> mode_o[6]);
    // R10
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we && !mode_we) |=> !mode_o[6]);
    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !lo_we && !hi_we) |=> (cmp_o == $past(cnt) && flag_o));
    // R7
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_o);

endmodule

// File: rtl/ctr_compare_array.sv
module ctr_compare_array
    import cca_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              idle,
    input  logic              t0_ovf,
    input  logic              eci,
    input  logic [NUM_CH-1:0] cex_in,
    output logic [NUM_CH-1:0] cex_out,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
    } top_t;

    top_t q, d;
    logic raw_tick, step, cnt_we;
    logic [NUM_CH-1:0] flags, reqs;
    logic [7:0]        modes [NUM_CH];
    logic [CNT_W-1:0]  cmps  [NUM_CH];

    cca_tick #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .sel(src_t'(q.ctrl[2:1])),
        .t0_ovf(t0_ovf), .eci(eci), .tick(raw_tick)
    );

    assign step   = raw_tick & q.ctrl[C_RUN] & ~(idle & q.ctrl[C_IDLE]);
    assign cnt_we = reg_we & (reg_addr == ADDR_W'(A_CNTL) || reg_addr == ADDR_W'(A_CNTH));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            cca_channel #(.DATA_W(DATA_W)) i_ch (
                .clk(clk), .rst_n(rst_n), .step(step), .cnt(q.cnt),
                .mode_we(reg_we && reg_addr == ADDR_W'(A_MODE + i)),
                .lo_we  (reg_we && reg_addr == ADDR_W'(A_CMPL + i)),
                .hi_we  (reg_we && reg_addr == ADDR_W'(A_CMPH + i)),
                .flag_we(reg_we && reg_addr == ADDR_W'(A_FLAGS)),
                .flag_wbit(reg_wdata[i]), .wdata(reg_wdata),
                .pin_in(cex_in[i]), .mode_o(modes[i]), .cmp_o(cmps[i]),
                .flag_o(flags[i]), .pin_out(cex_out[i]), .req(reqs[i])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        if (step) d.cnt = q.cnt + 1'b1;
        if (reg_we) begin
            if (reg_addr == ADDR_W'(A_CTRL))  d.ctrl = {3'b000, reg_wdata[4:0]};
            if (reg_addr == ADDR_W'(A_CNTL))  d.cnt[DATA_W-1:0] = reg_wdata;
            if (reg_addr == ADDR_W'(A_CNTH))  d.cnt[CNT_W-1:DATA_W] = reg_wdata;
            if (reg_addr == ADDR_W'(A_FLAGS)) d.ovf = reg_wdata[DATA_W-1];
        end
        if (step && q.cnt == '1) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = q.ctrl;
        if (reg_addr == ADDR_W'(A_FLAGS)) begin
            reg_rdata[NUM_CH-1:0] = flags;
            reg_rdata[DATA_W-1]   = q.ovf;
        end
        if (reg_addr == ADDR_W'(A_CNTL)) reg_rdata = q.cnt[DATA_W-1:0];
        if (reg_addr == ADDR_W'(A_CNTH)) reg_rdata = q.cnt[CNT_W-1:DATA_W];
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(A_MODE + i)) reg_rdata = modes[i];
            if (reg_addr == ADDR_W'(A_CMPL + i)) reg_rdata = cmps[i][DATA_W-1:0];
            if (reg_addr == ADDR_W'(A_CMPH + i)) reg_rdata = cmps[i][CNT_W-1:DATA_W];
        end
    end

    assign irq = (q.ovf & q.ctrl[C_OVFIE]) | (|reqs);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && q.ctrl[C_IDLE] && !cnt_we) |=> $stable(q.cnt));
    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q.cnt == '1 && !cnt_we) |=> (q.ovf && q.cnt == '0));
    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl[C_RUN] && !cnt_we) |=> $stable(q.cnt));

endmodule

// File: tb/test_ctr_compare_array.sv
module test_ctr_compare_array;
    logic       clk = 0, rst_n = 0, reg_we = 0, idle = 0, t0_ovf = 0, eci = 0;
    logic [4:0] reg_addr = 0, cex_in = 0, cex_out;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       irq;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    ctr_compare_array i_ctr_compare_array (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle),
        .t0_ovf(t0_ovf), .eci(eci), .cex_in(cex_in), .cex_out(cex_out), .irq(irq)
    );

    function automatic logic exp_pwm(input logic [7:0] c, input logic [7:0] duty);
        return c >= duty;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(5'h02, lo); rd(5'h03, hi); v = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(5'h02, v[7:0]); wr(5'h03, v[15:8]);
    endtask

    task automatic pulse_t0;
        @(negedge clk); t0_ovf = 1; @(negedge clk); t0_ovf = 0;
    endtask

    task automatic done;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] c0, c1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state, R14-style map readback
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v); check("R1 reg", {24'd0, v}, 0);
        end
        check("R1 cex_out", {27'd0, cex_out}, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 divide by 6 and by 2
        wr(5'h00, 8'h01);
        rd16(c0); repeat (60) @(negedge clk); rd16(c1);
        check("R2 div6", 32'(c1 - c0), 10);
        wr(5'h00, 8'h03);
        rd16(c0); repeat (60) @(negedge clk); rd16(c1);
        check("R2 div2", 32'(c1 - c0), 30);
        // R2 external rising edges
        wr(5'h00, 8'h07);
        rd16(c0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); eci = 1; repeat (2) @(negedge clk); eci = 0; @(negedge clk);
        end
        rd16(c1); check("R2 eci", 32'(c1 - c0), 5);
        // R2 timer-overflow source, then run bit clear
        wr(5'h00, 8'h05);
        rd16(c0); repeat (3) pulse_t0(); rd16(c1);
        check("R2 t0", 32'(c1 - c0), 3);
        wr(5'h00, 8'h04);
        rd16(c0); pulse_t0(); rd16(c1);
        check("R2 run off", 32'(c1 - c0), 0);

        // R3 idle stop
        wr(5'h00, 8'h0D); idle = 1;
        rd16(c0); pulse_t0(); rd16(c1);
        check("R3 idle hold", 32'(c1 - c0), 0);
        idle = 0; pulse_t0(); rd16(c1);
        check("R3 idle off", 32'(c1 - c0), 1);

        // R4 overflow, R5 software clear
        wr(5'h00, 8'h05); set_cnt(16'hFFFF); pulse_t0();
        rd16(c1); check("R4 wrap", {16'd0, c1}, 0);
        rd(5'h01, v); check("R4 flag", {31'd0, v[7]}, 1);
        check("R4 irq masked", {31'd0, irq}, 0);
        wr(5'h00, 8'h15); check("R4 irq enabled", {31'd0, irq}, 1);
        wr(5'h01, 8'h00); rd(5'h01, v);
        check("R5 clear", {24'd0, v}, 0);
        check("R5 irq low", {31'd0, irq}, 0);
        wr(5'h00, 8'h05);

        // R6 mode bit 7 reads zero
        wr(5'h0C, 8'hFF); rd(5'h0C, v); check("R6 mode", {24'd0, v}, 32'h7F);
        wr(5'h0C, 8'h00);

        // R10 arm/disarm via compare halves
        wr(5'h18, 8'h12); rd(5'h08, v); check("R10 arm", {31'd0, v[6]}, 1);
        wr(5'h10, 8'h34); rd(5'h08, v); check("R10 disarm", {31'd0, v[6]}, 0);

        // R7 software timer with random values
        wr(5'h08, 8'h48);
        for (int k = 0; k < 24; k++) begin
            logic [15:0] cv, off;
            cv  = 16'($urandom);
            off = 16'($urandom % 3);
            set_cnt(cv);
            wr(5'h10, 8'(cv + off)); wr(5'h18, 8'((cv + off) >> 8));
            wr(5'h01, 8'h00);
            pulse_t0();
            rd(5'h01, v);
            check("R7 match", {31'd0, v[0]}, (off == 0) ? 1 : 0);
        end

        // R13 channel interrupt enable
        wr(5'h01, 8'h00); wr(5'h08, 8'h49);
        set_cnt(16'h0500); wr(5'h10, 8'h00); wr(5'h18, 8'h05);
        check("R13 no flag", {31'd0, irq}, 0);
        pulse_t0(); check("R13 irq", {31'd0, irq}, 1);
        wr(5'h08, 8'h48); check("R13 masked", {31'd0, irq}, 0);
        wr(5'h01, 8'h00);

        // R8 toggle on match (channel 1)
        wr(5'h11, 8'h00); wr(5'h19, 8'h20); wr(5'h09, 8'h4C);
        set_cnt(16'h2000); pulse_t0();
        check("R8 toggle 1", {31'd0, cex_out[1]}, 1);
        set_cnt(16'h2000); pulse_t0();
        check("R8 toggle 2", {31'd0, cex_out[1]}, 0);
        wr(5'h09, 8'h00);

        // R9 capture with frozen counter
        wr(5'h00, 8'h04); wr(5'h01, 8'h00);
        wr(5'h0A, 8'h20); wr(5'h0B, 8'h10); wr(5'h0C, 8'h30);
        set_cnt(16'h1234);
        @(negedge clk); cex_in = 5'b11100; @(negedge clk);
        rd(5'h01, v); check("R9 rise flags", {27'd0, v[4:0]}, 32'b10100);
        rd(5'h12, v); check("R9 cap lo", {24'd0, v}, 32'h34);
        rd(5'h1A, v); check("R9 cap hi", {24'd0, v}, 32'h12);
        set_cnt(16'hBEEF); wr(5'h01, 8'h00);
        @(negedge clk); cex_in = 5'b00000; @(negedge clk);
        rd(5'h01, v); check("R9 fall flags", {27'd0, v[4:0]}, 32'b11000);
        rd(5'h13, v); check("R9 capn lo", {24'd0, v}, 32'hEF);
        rd(5'h1C, v); check("R9 both hi", {24'd0, v}, 32'hBE);
        rd(5'h1A, v); check("R9 no fall cap", {24'd0, v}, 32'h12);
        wr(5'h0A, 8'h00); wr(5'h0B, 8'h00); wr(5'h0C, 8'h00); wr(5'h01, 8'h00);

        // R11 PWM level, random duty and count
        for (int k = 0; k < 20; k++) begin
            logic [7:0]  duty;
            logic [15:0] cv;
            duty = 8'($urandom);
            cv   = 16'($urandom);
            if (k == 0) begin duty = 8'h00; cv = 16'h0000; end
            if (k == 1) begin duty = 8'hFF; cv = 16'h00FE; end
            wr(5'h11, duty); wr(5'h19, duty); wr(5'h09, 8'h42);
            set_cnt(cv);
            check("R11 pwm", {31'd0, cex_out[1]}, {31'd0, exp_pwm(cv[7:0], duty)});
        end

        // R12 PWM reload on low-byte wrap
        wr(5'h00, 8'h05);
        wr(5'h11, 8'h10); wr(5'h19, 8'h80); wr(5'h09, 8'h42);
        set_cnt(16'h00FF);
        check("R12 before", {31'd0, cex_out[1]}, 1);
        pulse_t0();
        rd(5'h11, v); check("R12 reload", {24'd0, v}, 32'h80);
        check("R12 out", {31'd0, cex_out[1]}, 0);

        done();
    end
endmodule